// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

The block turns a handful of clock-control fields into the frequency, in hertz, of one node of a clock tree. A requester names a node with a 4-bit code while the block is idle. The block then walks the tree from a 24 MHz reference to that node and returns the result together with a one-cycle completion pulse. The tree starts at a system PLL whose multiplier is chosen by one bit. Two fractional taps hang off the PLL, each producing PLL × 18 / fraction. A 4-way source select feeds the peripheral root. Three cascaded divide-by-(1+N) stages follow: bus, IPG and peripheral-timer.

Every division runs on one shared restoring divider that produces one quotient bit per clock. Each tree level therefore costs a fixed number of cycles, and the latency depends only on how deep the requested node sits. The crystal, the crystal divided by eight and the 32 kHz source need no arithmetic and answer at once. Control fields are captured when a request is taken, so software may rewrite them while a computation runs.

Top module: `clk_tree_freq`

## Requirements
- R1: While reset is held and after its release, `done` and `busy` are 0 and `freq` is 0.
- R2: Node code 5 returns 24000000, code 6 returns 3000000 and code 7 returns 32768. `done` is high in the cycle after the accepting edge, and `busy` never rises for these codes.
- R3: Node code 0 and every code from 8 to 15 return 0, with the same timing as R2.
- R4: The PLL runs at 528000000 Hz when `pll_sel` is 1 and at 480000000 Hz when it is 0. Node code 1 (peripheral root) with `src_sel` 0 returns that PLL value.
- R5: For the peripheral root, `src_sel` 1 gives floor(PLL×18/`frac_b`), `src_sel` 2 gives floor(PLL×18/`frac_a`), and `src_sel` 3 gives floor(PLL×18/`frac_b`)/2, rounded down.
- R6: When the fraction field chosen by `src_sel` (1..3) is 0, the peripheral root and everything below it evaluate to 0.
- R7: Code 2 (bus) = root/(1+`bus_div`), code 3 (IPG) = bus/(1+`ipg_div`) and code 4 (timer) = IPG/(1+`per_div`). Each quotient is rounded down.
- R8: For codes 1, 2, 3 and 4, `done` rises 128, 192, 256 and 320 cycles after the accepting edge, respectively, and stays high for exactly one cycle.
- R9: `busy` is high from the accepting edge until the edge that raises `done`. A request presented while `busy` is high is ignored.
- R10: All control fields are sampled at the accepting edge. Changing them during a computation does not change its result.
- R11: `freq` changes only on an edge that raises `done`, and otherwise holds its value.
- R12: Intermediate values are kept at 64 bits, and `freq` carries the low 32 bits of the final value. For example, `pll_sel`=1, `src_sel`=1, `frac_b`=1 gives 914065408.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_id | input | 4 | Node code (see R2–R7) |
| pll_sel | input | 1 | PLL multiplier select: 1 → ×22, 0 → ×20 |
| src_sel | input | 2 | Peripheral root source select |
| frac_a | input | 6 | Fraction of tap A (used by src_sel 2) |
| frac_b | input | 6 | Fraction of tap B (used by src_sel 1 and 3) |
| bus_div | input | 3 | Bus post-divider field |
| ipg_div | input | 2 | IPG post-divider field |
| per_div | input | 6 | Timer post-divider field |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result pulse |
| freq | output | 32 | Result in Hz |

## Verification
The bench uses the default parameters: a 24 MHz reference, a 64-bit divider and 6-bit fraction fields. With these values the full 9.5 GHz tap intermediate is reachable, so the 32-bit truncation of R12 can be exercised with a fraction of 1. The ×22 and ×20 PLL settings and the full 1..64 timer divider range are also reachable. The deepest node costs 320 cycles at this divider width, which keeps exact-latency checks and mid-computation field rewrites cheap. A zero fraction is checked on both taps.

// File: rtl/clk_tree_freq.sv
module clk_tree_freq #(
  parameter int unsigned REF_HZ   = 24000000,
  parameter int unsigned SLOW_HZ  = 32768,
  parameter int unsigned MUL_LO   = 20,
  parameter int unsigned MUL_HI   = 22,
  parameter int unsigned TAP_MUL  = 18,
  parameter int unsigned XTAL_DIV = 8,
  parameter int FRAC_W = 6,
  parameter int BUS_W  = 3,
  parameter int IPG_W  = 2,
  parameter int PER_W  = 6,
  parameter int DIV_W  = 64,
  parameter int OUT_W  = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic              pll_sel,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  input  logic [BUS_W-1:0]  bus_div,
  input  logic [IPG_W-1:0]  ipg_div,
  input  logic [PER_W-1:0]  per_div,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  freq
);

  localparam int M1    = (FRAC_W > BUS_W) ? FRAC_W : BUS_W;
  localparam int M2    = (IPG_W > PER_W) ? IPG_W : PER_W;
  localparam int DEN_W = ((M1 > M2) ? M1 : M2) + 1;
  localparam int CNT_W = $clog2(DIV_W);
  localparam logic [DIV_W-1:0] PLL_LO = DIV_W'(REF_HZ) * DIV_W'(MUL_LO);
  localparam logic [DIV_W-1:0] PLL_HI = DIV_W'(REF_HZ) * DIV_W'(MUL_HI);
  localparam logic [ID_W-1:0]  ID_XTAL  = ID_W'(5);
  localparam logic [ID_W-1:0]  ID_XTAL8 = ID_W'(6);
  localparam logic [ID_W-1:0]  ID_SLOW  = ID_W'(7);
  localparam logic [ID_W-1:0]  ID_LAST  = ID_W'(4);

  logic              busy_q, done_q;
  logic [OUT_W-1:0]  freq_q;
  logic [DIV_W-1:0]  q_q;
  logic [DEN_W-1:0]  rem_q, den_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        stage_q, last_q;
  logic [1:0]        src_q;
  logic [BUS_W-1:0]  bus_q;
  logic [IPG_W-1:0]  ipg_q;
  logic [PER_W-1:0]  per_q;

  wire accept  = req_valid && !busy_q;
  wire is_calc = (req_id != '0) && (req_id <= ID_LAST);

  logic [OUT_W-1:0] const_val;
  always_comb begin
    case (req_id)
      ID_XTAL:  const_val = OUT_W'(REF_HZ);
      ID_XTAL8: const_val = OUT_W'(REF_HZ / XTAL_DIV);
      ID_SLOW:  const_val = OUT_W'(SLOW_HZ);
      default:  const_val = '0;
    endcase
  end

  wire [DIV_W-1:0]  pll = pll_sel ? PLL_HI : PLL_LO;
  wire [FRAC_W-1:0] tap = (src_sel == 2'd2) ? frac_a : frac_b;
  logic [DIV_W-1:0] num0;
  logic [DEN_W-1:0] den0;
  always_comb begin
    if (src_sel == 2'd0) begin
      num0 = pll;
      den0 = DEN_W'(1);
    end else if (tap == '0) begin
      num0 = '0;
      den0 = DEN_W'(1);
    end else begin
      num0 = pll * DIV_W'(TAP_MUL);
      den0 = DEN_W'(tap);
    end
  end

  logic [DEN_W-1:0] nxt_den;
  always_comb begin
    case (stage_q)
      3'd0:    nxt_den = (src_q == 2'd3) ? DEN_W'(2) : DEN_W'(1);
      3'd1:    nxt_den = DEN_W'(bus_q) + DEN_W'(1);
      3'd2:    nxt_den = DEN_W'(ipg_q) + DEN_W'(1);
      default: nxt_den = DEN_W'(per_q) + DEN_W'(1);
    endcase
  end

  wire [DEN_W:0]   rem_sh = {rem_q, q_q[DIV_W-1]};
  wire             ge     = rem_sh >= {1'b0, den_q};
  wire [DEN_W:0]   rem_n  = ge ? rem_sh - {1'b0, den_q} : rem_sh;
  wire [DIV_W-1:0] q_n    = {q_q[DIV_W-2:0], ge};
  wire             last_bit = cnt_q == CNT_W'(DIV_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      freq_q  <= '0;
      q_q     <= '0;
      rem_q   <= '0;
      den_q   <= DEN_W'(1);
      cnt_q   <= '0;
      stage_q <= '0;
      last_q  <= '0;
      src_q   <= '0;
      bus_q   <= '0;
      ipg_q   <= '0;
      per_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        q_q   <= q_n;
        rem_q <= rem_n[DEN_W-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (last_bit) begin
          cnt_q <= '0;
          rem_q <= '0;
          if (stage_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            freq_q <= q_n[OUT_W-1:0];
          end else begin
            stage_q <= stage_q + 3'd1;
            den_q   <= nxt_den;
          end
        end
      end else if (accept) begin
        if (is_calc) begin
          busy_q  <= 1'b1;
          q_q     <= num0;
          den_q   <= den0;
          rem_q   <= '0;
          cnt_q   <= '0;
          stage_q <= '0;
          last_q  <= req_id[2:0];
          src_q   <= src_sel;
          bus_q   <= bus_div;
          ipg_q   <= ipg_div;
          per_q   <= per_div;
        end else begin
          done_q <= 1'b1;
          freq_q <= const_val;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign freq = freq_q;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done && freq == '0);

  p_xtal_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_id == ID_XTAL) |=> done && !busy && freq == OUT_W'(REF_HZ));

  p_none_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_id == '0 || req_id > ID_SLOW)) |=> done && !busy && freq == '0);

  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_freq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(freq));

endmodule

// File: tb/tb_clk_tree_freq.sv
`timescale 1ns/1ps
module tb_clk_tree_freq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_id = '0;
  logic       pll_sel = 1'b1;
  logic [1:0] src_sel = '0;
  logic [5:0] frac_a = 6'd27, frac_b = 6'd27;
  logic [2:0] bus_div = '0;
  logic [1:0] ipg_div = '0;
  logic [5:0] per_div = '0;
  logic       busy, done;
  logic [31:0] freq;

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  clk_tree_freq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .pll_sel(pll_sel), .src_sel(src_sel), .frac_a(frac_a), .frac_b(frac_b),
    .bus_div(bus_div), .ipg_div(ipg_div), .per_div(per_div),
    .busy(busy), .done(done), .freq(freq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned ref_freq(input int id);
    longint unsigned pll, root, b, ip;
    pll = pll_sel ? 64'd528000000 : 64'd480000000;
    case (src_sel)
      2'd0: root = pll;
      2'd1: root = (frac_b == 0) ? 0 : pll * 18 / frac_b;
      2'd2: root = (frac_a == 0) ? 0 : pll * 18 / frac_a;
      default: root = ((frac_b == 0) ? 0 : pll * 18 / frac_b) / 2;
    endcase
    b  = root / (bus_div + 1);
    ip = b / (ipg_div + 1);
    case (id)
      1: return root;
      2: return b;
      3: return ip;
      4: return ip / (per_div + 1);
      5: return 24000000;
      6: return 3000000;
      7: return 32768;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_lat(input int id);
    return (id >= 1 && id <= 4) ? 64 * (id + 1) : 0;
  endfunction

  bit m_busy = 0, m_done = 0;
  int m_left = 0;
  longint unsigned m_pend = 0;
  logic [31:0] m_freq = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_freq = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_freq = m_pend[31:0];
        end
      end else if (req_valid) begin
        m_pend = ref_freq(int'(req_id));
        m_left = ref_lat(int'(req_id));
        if (m_left == 0) begin
          m_done = 1; m_freq = m_pend[31:0];
        end else m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done == m_done && busy == m_busy && freq == m_freq, {cur_tag, " per-cycle model"},
          {30'd0, done, busy, freq}, {30'd0, m_done, m_busy, m_freq});
    end
  end

  task automatic run(input int id, input longint unsigned exp, input int exp_lat,
                     input string tag, input bit scramble = 0, input bit poke = 0);
    int n;
    cur_tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_id = 4'(id);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      pll_sel = ~pll_sel; src_sel = ~src_sel; frac_a = 6'd1; frac_b = 6'd0;
      bus_div = ~bus_div; ipg_div = ~ipg_div; per_div = ~per_div;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 10) begin req_valid = 1'b1; req_id = 4'd5; end
      if (poke && n == 20) req_valid = 1'b0;
    end
    chk(freq == exp[31:0], {tag, " value"}, freq, exp[31:0]);
    if (exp_lat >= 0) chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !busy && freq == 0, "R1 during reset", {done, busy, freq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && freq == 0, "R1 after reset", {done, busy, freq}, 0);

    pll_sel = 1; src_sel = 0;
    run(1, 528000000, 128, "R4 pll x22");
    pll_sel = 0;
    run(1, 480000000, 128, "R4 pll x20");

    pll_sel = 1; src_sel = 1; frac_b = 27;
    run(1, 352000000, 128, "R5 tap b");
    src_sel = 2; frac_a = 24;
    run(1, 396000000, 128, "R5 tap a");
    src_sel = 3; frac_b = 27;
    run(1, 176000000, 128, "R5 half tap b");
    pll_sel = 0; src_sel = 1; frac_b = 35;
    run(1, 246857142, 128, "R5 floor");

    pll_sel = 1; src_sel = 1; frac_b = 0;
    run(1, 0, 128, "R6 zero frac b");
    src_sel = 2; frac_a = 0;
    run(4, 0, 320, "R6 zero frac a timer");

    src_sel = 0; bus_div = 3; ipg_div = 1; per_div = 5;
    run(2, 132000000, 192, "R7 bus R8");
    run(3, 66000000, 256, "R7 ipg R8");
    run(4, 11000000, 320, "R7 timer R8");
    per_div = 6;
    run(4, 9428571, 320, "R7 timer floor");

    src_sel = 1; frac_b = 1; bus_div = 0; ipg_div = 0; per_div = 0;
    run(1, 914065408, 128, "R12 truncation");

    run(5, 24000000, 0, "R2 crystal");
    run(6, 3000000, 0, "R2 crystal div");
    run(7, 32768, 0, "R2 slow");
    run(0, 0, 0, "R3 none");
    run(9, 0, 0, "R3 code 9");
    run(15, 0, 0, "R3 code 15");

    pll_sel = 1; src_sel = 0; bus_div = 3; ipg_div = 1; per_div = 5;
    run(4, 11000000, 320, "R10 fields rewritten", 1'b1);

    pll_sel = 1; src_sel = 0; bus_div = 0; ipg_div = 0; per_div = 0;
    run(1, 528000000, 128, "R9 request while busy", 1'b0, 1'b1);

    cur_tag = "R11";
    repeat (6) @(negedge clk);
    chk(freq == 528000000 && !done, "R11 hold", freq, 528000000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule